// File: doc/BRIEF.md
# Conditional Execution and Compare Unit

This block holds the two status flags of a small trigger-processing sequencer: a compare flag (C) and a secondary flag (S). For every issued instruction it decides, from the instruction's 2-bit condition field and the current flags, whether the instruction executes or is skipped. When an executing instruction is a compare, the block forms a three-way less/zero/greater outcome from two 30-bit register operands. A small constant may be added to either operand first. C is then set or cleared by testing that outcome against a 3-bit mask.

The unit also keeps the sequencer's "last result" value and produces the write-back word for the register slot tied to the current program address. A skipped instruction writes back the last result. A compare writes back its X operand. Other executing instructions write back their own result when they have one. A generic flag-load port lets the neighbouring bit-test logic set C or S. Flag changes are visible to the condition decision of the instruction issued in the following cycle.

Top module: `cond_cmp_unit`

## Requirements
- R1: After the active-low asynchronous reset, flag_c_o, flag_s_o and last_o are all zero.
- R2: exec_o depends combinationally on cond_i and the registered flags. Code 0 always executes, code 1 executes when S is 1, code 2 executes when C is 0, and code 3 executes when C is 1.
- R3: A cycle with valid_i low, or with valid_i high and exec_o low, leaves C, S and last_o unchanged at the next edge.
- R4: When valid_i is high and exec_o is low, wb_data_o equals last_o.
- R5: On a compare, offs_i is zero-extended and added to op_y_i when offs_on_y_i is 1, or to op_x_i when it is 0. D is then X minus Y, taken in 32-bit two's complement.
- R6: The outcome has bit 0 for negative, bit 1 for zero and bit 2 for positive. Negative means D bit 29 is set, zero means D equals 0, and positive covers every other case, so some very large differences count as positive. At the next edge after an executed compare, C becomes 1 if (outcome AND mask_i) is nonzero and becomes 0 otherwise.
- R7: An executed compare never changes S. In that cycle the compare takes priority over res_we_i and flag_we_i.
- R8: In the cycle of an executed compare, wb_data_o equals op_x_i, and last_o takes op_x_i at the next edge.
- R9: An executed non-compare instruction with res_we_i high drives wb_data_o with res_i, and last_o takes res_i at the next edge. With res_we_i low, wb_data_o equals last_o and last_o holds.
- R10: An executed non-compare instruction with flag_we_i high loads flag_val_i into C when flag_sel_i is 0, or into S when flag_sel_i is 1. The other flag is left unchanged.
- R11: A flag updated at an edge sets exec_o for the instruction presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is issued this cycle |
| cond_i | input | 2 | Condition field of the issued instruction |
| cmp_i | input | 1 | Instruction is a compare |
| op_x_i | input | 30 | Compare operand X |
| op_y_i | input | 30 | Compare operand Y |
| offs_i | input | 8 | Compare offset constant |
| offs_on_y_i | input | 1 | 1: offset added to Y, 0: offset added to X |
| mask_i | input | 3 | Outcome mask (bit0 neg, bit1 zero, bit2 pos) |
| res_we_i | input | 1 | Non-compare instruction produces a result |
| res_i | input | 30 | Result of the non-compare instruction |
| flag_we_i | input | 1 | Load a flag from flag_val_i |
| flag_sel_i | input | 1 | Flag to load: 0 selects C, 1 selects S |
| flag_val_i | input | 1 | Value to load into the selected flag |
| exec_o | output | 1 | Instruction executes (1) or is skipped (0) |
| wb_data_o | output | 30 | Write-back word for the current address slot |
| last_o | output | 30 | Registered last result |
| flag_c_o | output | 1 | Compare flag C |
| flag_s_o | output | 1 | Secondary flag S |

## Verification
The compare is driven with equal operands, and with operands that become equal only once the offset is applied to one side or the other. This separates the two offset paths. Small differences in both directions test the neg and pos outcomes under single-bit masks. Extreme operands whose difference leaves bit 29 clear, and an all-zero mask, show that C follows bit 29 of D rather than the true sign. Each of the four condition codes is tried both with its flag set and with it clear. A long random mix of skips, compares, flag loads and result writes is then compared against a cycle model, which catches wrong priorities and stale flags in the following cycle.

// File: rtl/ceu_pkg.sv
package ceu_pkg;
  localparam int unsigned OUT_W = 3;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'd0,
    COND_S_SET  = 2'd1,
    COND_C_CLR  = 2'd2,
    COND_C_SET  = 2'd3
  } cond_e;

  typedef struct packed {
    logic pos;
    logic zero;
    logic neg;
  } outcome_t;
endpackage

// File: rtl/ceu_cond_eval.sv
module ceu_cond_eval
  import ceu_pkg::*;
(
  input  logic [1:0] cond_i,
  input  logic       flag_c_i,
  input  logic       flag_s_i,
  output logic       exec_o
);
  cond_e cond;
  assign cond = cond_e'(cond_i);

  always_comb begin
    unique case (cond)
      COND_ALWAYS: exec_o = 1'b1;
      COND_S_SET:  exec_o = flag_s_i;
      COND_C_CLR:  exec_o = ~flag_c_i;
      COND_C_SET:  exec_o = flag_c_i;
      default:     exec_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ceu_compare.sv
module ceu_compare
  import ceu_pkg::*;
#(
  parameter int unsigned DW   = 30,
  parameter int unsigned OFFW = 8
) (
  input  logic [DW-1:0]    op_x_i,
  input  logic [DW-1:0]    op_y_i,
  input  logic [OFFW-1:0]  offs_i,
  input  logic             offs_on_y_i,
  input  logic [OUT_W-1:0] mask_i,
  output outcome_t         outcome_o,
  output logic             hit_o
);
  localparam int unsigned DDW = DW + 2;

  logic [DDW-1:0] x_ext, y_ext, off_ext, diff;

  always_comb begin
    off_ext = DDW'(offs_i);
    x_ext   = DDW'(op_x_i);
    y_ext   = DDW'(op_y_i);
    if (offs_on_y_i) y_ext = y_ext + off_ext;
    else             x_ext = x_ext + off_ext;
    diff = x_ext - y_ext;
  end

  // sign taken from bit DW-1 only, wider bits ignored
  always_comb begin
    outcome_o.neg  = diff[DW-1];
    outcome_o.zero = (diff == '0);
    outcome_o.pos  = ~diff[DW-1] & (diff != '0);
  end

  assign hit_o = |(outcome_o & mask_i);
endmodule

// File: rtl/ceu_state.sv
module ceu_state #(
  parameter int unsigned DW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_cmp_i,
  input  logic          cmp_hit_i,
  input  logic [DW-1:0] op_x_i,
  input  logic          upd_res_i,
  input  logic [DW-1:0] res_i,
  input  logic          upd_flag_i,
  input  logic          flag_sel_i,
  input  logic          flag_val_i,
  output logic          flag_c_o,
  output logic          flag_s_o,
  output logic [DW-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_c_o <= 1'b0;
      flag_s_o <= 1'b0;
    end else if (upd_cmp_i) begin
      flag_c_o <= cmp_hit_i;
    end else if (upd_flag_i) begin
      if (flag_sel_i) flag_s_o <= flag_val_i;
      else            flag_c_o <= flag_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_o <= '0;
    else if (upd_cmp_i) last_o <= op_x_i;
    else if (upd_res_i) last_o <= res_i;
  end

  assert_cmp_c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_cmp_i |=> flag_c_o == $past(cmp_hit_i));
  assert_flag_c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_flag_i && !upd_cmp_i && !flag_sel_i) |=> flag_c_o == $past(flag_val_i) && $stable(flag_s_o));
  assert_flag_s_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_flag_i && !upd_cmp_i && flag_sel_i) |=> flag_s_o == $past(flag_val_i) && $stable(flag_c_o));
endmodule

// File: rtl/cond_cmp_unit.sv
module cond_cmp_unit
  import ceu_pkg::*;
#(
  parameter int unsigned DW   = 30,
  parameter int unsigned OFFW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      cond_i,
  input  logic            cmp_i,
  input  logic [DW-1:0]   op_x_i,
  input  logic [DW-1:0]   op_y_i,
  input  logic [OFFW-1:0] offs_i,
  input  logic            offs_on_y_i,
  input  logic [2:0]      mask_i,
  input  logic            res_we_i,
  input  logic [DW-1:0]   res_i,
  input  logic            flag_we_i,
  input  logic            flag_sel_i,
  input  logic            flag_val_i,
  output logic            exec_o,
  output logic [DW-1:0]   wb_data_o,
  output logic [DW-1:0]   last_o,
  output logic            flag_c_o,
  output logic            flag_s_o
);
  logic     go, upd_cmp, upd_res, upd_flag, cmp_hit;
  outcome_t outcome;

  ceu_cond_eval i_cond (
    .cond_i   (cond_i),
    .flag_c_i (flag_c_o),
    .flag_s_i (flag_s_o),
    .exec_o   (exec_o)
  );

  ceu_compare #(.DW(DW), .OFFW(OFFW)) i_cmp (
    .op_x_i      (op_x_i),
    .op_y_i      (op_y_i),
    .offs_i      (offs_i),
    .offs_on_y_i (offs_on_y_i),
    .mask_i      (mask_i),
    .outcome_o   (outcome),
    .hit_o       (cmp_hit)
  );

  assign go       = valid_i & exec_o;
  assign upd_cmp  = go & cmp_i;
  assign upd_res  = go & ~cmp_i & res_we_i;
  assign upd_flag = go & ~cmp_i & flag_we_i;

  ceu_state #(.DW(DW)) i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_cmp_i  (upd_cmp),
    .cmp_hit_i  (cmp_hit),
    .op_x_i     (op_x_i),
    .upd_res_i  (upd_res),
    .res_i      (res_i),
    .upd_flag_i (upd_flag),
    .flag_sel_i (flag_sel_i),
    .flag_val_i (flag_val_i),
    .flag_c_o   (flag_c_o),
    .flag_s_o   (flag_s_o),
    .last_o     (last_o)
  );

  always_comb begin
    if (upd_cmp)      wb_data_o = op_x_i;
    else if (upd_res) wb_data_o = res_i;
    else              wb_data_o = last_o;
  end

  assert_always_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 2'd0) |-> exec_o);
  assert_skip_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && exec_o) |=> $stable(flag_c_o) && $stable(flag_s_o) && $stable(last_o));
  assert_skip_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !exec_o) |-> wb_data_o == last_o);
  assert_cmp_keep_s_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exec_o && cmp_i) |=> $stable(flag_s_o));
  assert_cmp_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exec_o && cmp_i) |=> last_o == $past(op_x_i));
  assert_res_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exec_o && !cmp_i && res_we_i) |=> last_o == $past(res_i));
endmodule

// File: tb/test_cond_cmp_unit.sv
module test_cond_cmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, cmp_i = 1'b0, offs_on_y_i = 1'b0;
  logic [1:0]  cond_i = '0;
  logic [29:0] op_x_i = '0, op_y_i = '0, res_i = '0;
  logic [7:0]  offs_i = '0;
  logic [2:0]  mask_i = '0;
  logic        res_we_i = 1'b0, flag_we_i = 1'b0, flag_sel_i = 1'b0, flag_val_i = 1'b0;
  logic        exec_o, flag_c_o, flag_s_o;
  logic [29:0] wb_data_o, last_o;

  int errors = 0, checks = 0;
  bit m_c = 0, m_s = 0;
  longint m_last = 0;

  always #4 clk_i = ~clk_i;

  cond_cmp_unit i_cond_cmp_unit (.*);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(longint x, longint y, longint off, bit on_y, bit [2:0] m);
    longint d;
    bit [31:0] d32;
    bit [2:0] oc;
    if (on_y) y = y + off; else x = x + off;
    d = x - y;
    d32 = d[31:0];
    if (d32[29])        oc = 3'b001;
    else if (d32 == 0)  oc = 3'b010;
    else                oc = 3'b100;
    return |(oc & m);
  endfunction

  task automatic step(bit v, bit [1:0] cd, bit cmp, longint x, longint y, longint off,
                      bit on_y, bit [2:0] m, bit rwe, longint r, bit fwe, bit fsel, bit fval);
    bit ex;
    longint wb;
    string tag;
    @(negedge clk_i);
    valid_i = v; cond_i = cd; cmp_i = cmp; op_x_i = 30'(x); op_y_i = 30'(y);
    offs_i = 8'(off); offs_on_y_i = on_y; mask_i = m; res_we_i = rwe; res_i = 30'(r);
    flag_we_i = fwe; flag_sel_i = fsel; flag_val_i = fval;
    #1;
    case (cd)
      2'd0: ex = 1;
      2'd1: ex = m_s;
      2'd2: ex = !m_c;
      default: ex = m_c;
    endcase
    check("R2/R11 exec", exec_o, ex);
    if (v && ex && cmp)      begin wb = x; tag = "R8 wb"; end
    else if (v && ex && rwe) begin wb = r; tag = "R9 wb"; end
    else                     begin wb = m_last; tag = (v && !ex) ? "R4 wb" : "R9 wb"; end
    check(tag, wb_data_o, wb);
    if (v && ex) begin
      if (cmp) begin
        m_c = model_hit(x, y, off, on_y, m);
        m_last = x;
        tag = "R5/R6/R7/R8";
      end else begin
        if (rwe) m_last = r;
        if (fwe) begin
          if (fsel) m_s = fval; else m_c = fval;
        end
        tag = "R9/R10";
      end
    end else tag = "R3";
    @(posedge clk_i);
    #1;
    check({tag, " C"}, flag_c_o, m_c);
    check({tag, " S"}, flag_s_o, m_s);
    check({tag, " last"}, last_o, m_last);
  endtask

  task automatic set_flag(bit sel, bit val);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, sel, val);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    check("R1 C", flag_c_o, 0);
    check("R1 S", flag_s_o, 0);
    check("R1 last", last_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R5/R6 directed compares
    step(1, 0, 1, 5, 5, 0, 0, 3'b010, 0, 0, 0, 0, 0);                 // zero
    step(1, 0, 1, 5, 3, 2, 1, 3'b010, 0, 0, 0, 0, 0);                 // offset on Y -> zero
    step(1, 0, 1, 3, 5, 2, 0, 3'b010, 0, 0, 0, 0, 0);                 // offset on X -> zero
    step(1, 0, 1, 5, 3, 2, 0, 3'b010, 0, 0, 0, 0, 0);                 // offset on X -> not zero
    step(1, 0, 1, 3, 5, 0, 0, 3'b001, 0, 0, 0, 0, 0);                 // neg hit
    step(1, 0, 1, 3, 5, 0, 0, 3'b100, 0, 0, 0, 0, 0);                 // neg, pos mask
    step(1, 0, 1, 9, 5, 0, 0, 3'b100, 0, 0, 0, 0, 0);                 // pos hit
    step(1, 0, 1, 0, 30'h3fffffff, 0, 0, 3'b100, 0, 0, 0, 0, 0);      // bit29 clear -> pos
    step(1, 0, 1, 30'h3fffffff, 0, 255, 0, 3'b100, 0, 0, 0, 0, 0);    // large positive
    step(1, 0, 1, 30'h3fffffff, 0, 0, 0, 3'b001, 0, 0, 0, 0, 0);      // bit29 set -> neg
    step(1, 0, 1, 7, 7, 0, 0, 3'b000, 0, 0, 0, 0, 0);                 // empty mask

    // R2/R10/R11 condition codes with flags set and clear
    set_flag(1, 1);
    step(1, 1, 0, 0, 0, 0, 0, 0, 1, 30'h123, 0, 0, 0);                // S set: exec
    set_flag(1, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0, 1, 30'h456, 0, 0, 0);                // S clear: skip R4
    set_flag(0, 1);
    step(1, 3, 0, 0, 0, 0, 0, 0, 1, 30'h789, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0, 1, 30'h0ab, 0, 0, 0);
    set_flag(0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0, 1, 30'h0cd, 0, 0, 0);
    step(1, 3, 1, 1, 1, 0, 0, 3'b111, 0, 0, 0, 0, 0);                 // skipped compare R3
    // R7 compare over flag write and result
    set_flag(1, 1);
    step(1, 0, 1, 2, 2, 0, 0, 3'b010, 1, 30'h111, 1, 1, 0);
    step(0, 0, 1, 4, 4, 0, 0, 3'b010, 1, 30'h222, 1, 0, 1);           // invalid R3

    for (int i = 0; i < 3000; i++) begin
      bit [2:0] kind = 3'($urandom_range(0, 5));
      longint x = (kind == 0) ? longint'($urandom_range(0, 40)) : longint'($urandom & 32'h3fffffff);
      longint y = (kind == 0) ? longint'($urandom_range(0, 40)) : longint'($urandom & 32'h3fffffff);
      step($urandom_range(0, 7) != 0, 2'($urandom), kind < 3, x, y,
           longint'($urandom_range(0, 255)), 1'($urandom), 3'($urandom),
           1'($urandom), longint'($urandom & 32'h3fffffff),
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule